// File: doc/BRIEF.md
# Sixteen-Bit Capture/Reload Timer with Serial Baud Ticks

The block is a 16-bit timer/counter with four operating modes chosen from its configuration: capture, auto-reload, auto-reload with direction taken from the trigger pin, and baud generation for a serial port. It advances on a clock-enable tick, or on falling edges of an external count input. A falling edge on the external trigger pin either snapshots the live count or forces a reload, depending on the mode. Wrap events set a sticky overflow flag. The same events can drive the transmit and receive baud ticks and toggle a dedicated output pin.

Software programs the block through a single write port with four word addresses:
- Address 0 is control. Bit 0 is run. Bit 1 enables the trigger pin. Bit 2 selects capture. Bit 3 takes the count from the external input. Bit 4 selects transmit baud. Bit 5 selects receive baud. Bit 6 is the external flag and bit 7 is the overflow flag; software writes both directly.
- Address 1 is options. Bit 0 enables down counting, bit 1 enables the toggle pin, and bit 2 enables the interrupt.
- Address 2 is the count. Address 3 is the reload/capture holding register.

A mode state machine holds one of five states: HALT, CAPTURE, RELOAD, UPDN and BAUD. Its transitions are:
- STOP: any state goes to HALT when run is clear.
- START: HALT goes to a mode state when run is set.
- RESELECT: one mode state moves to another when the configuration changes.

Mode precedence, from highest to lowest, is BAUD (either baud select set), then CAPTURE, then UPDN (down enable set), then RELOAD. The state follows a configuration write by one clock.

Top module: `evt_timer16`

## Requirements
- R1: After reset the count, holding register, both flags, the interrupt and the toggle pin are 0, and both baud selects are clear.
- R2: In HALT the count holds. Otherwise it advances once per cycle in which tick_i is 1, or, when control bit 3 is set, once per falling edge of cnt_in_i, and tick_i is then ignored.
- R3: In RELOAD mode, a step at count 16'hFFFF loads the holding register into the count and sets the overflow flag one clock after that step.
- R4: The overflow flag is cleared only by a software write of 0 to control bit 7. It never rises while control bit 4 or bit 5 is 1.
- R5: In CAPTURE mode with the trigger enabled, a trigger falling edge copies the live count into the holding register and sets the external flag; counting continues.
- R6: With control bit 1 clear, or in BAUD mode, trigger edges change neither the holding register, the count, nor the external flag.
- R7: In RELOAD mode with the trigger enabled, a trigger falling edge loads the holding register into the count and sets the external flag.
- R8: In UPDN mode, a high trigger level counts up and wraps to the holding value. A low level counts down; a step taken when the count equals the holding value loads 16'hFFFF and signals overflow.
- R9: irq_o is options bit 2 AND (overflow flag OR external flag), except that in UPDN the external flag does not raise irq_o.
- R10: Each baud output carries the timer's one-cycle overflow pulse when its select bit is 1, and mirrors t1_ovf_i otherwise.
- R11: With options bit 1 set, each overflow inverts tgl_o.
- R12: When a software write clears the overflow flag in the same cycle as a hardware overflow, the flag ends up set.
- R13: BAUD takes precedence over CAPTURE: with capture and a baud select both set, trigger edges do not capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count enable tick |
| cnt_in_i | input | 1 | External count input, falling edges count |
| trig_i | input | 1 | External trigger pin, also direction in UPDN |
| t1_ovf_i | input | 1 | Overflow pulse of the other timer |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register word address |
| wr_data_i | input | 16 | Register write data |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| ext_flag_o | output | 1 | Sticky external event flag |
| irq_o | output | 1 | Interrupt request |
| tx_baud_o | output | 1 | Transmit baud tick |
| rx_baud_o | output | 1 | Receive baud tick |
| tgl_o | output | 1 | Toggling output pin |
| count_o | output | 16 | Live count |
| hold_o | output | 16 | Reload/capture holding register |

## Verification
The overflow flag can be set by the counter wrapping and cleared by a software control write in the same clock. The bench provokes this by presenting a control write with bit 7 at 0 alongside a tick while the count is at 16'hFFFF. The case is judged correct when the flag reads 1 afterwards and the count has reloaded. A second coincidence is a trigger capture landing on a counting step. There, the holding register must receive the pre-step count, and an embedded property checks that relation on every capture.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    typedef enum logic [2:0] {
        ST_HALT,
        ST_CAPTURE,
        ST_RELOAD,
        ST_UPDN,
        ST_BAUD
    } tmr_state_e;

    typedef struct packed {
        logic run;
        logic ext_en;
        logic cap_mode;
        logic src_ext;
        logic tx_sel;
        logic rx_sel;
        logic down_en;
        logic out_en;
        logic irq_en;
    } tmr_cfg_t;

    localparam int unsigned ADDR_W     = 2;
    localparam logic [1:0]  ADDR_CTRL  = 2'd0;
    localparam logic [1:0]  ADDR_OPT   = 2'd1;
    localparam logic [1:0]  ADDR_COUNT = 2'd2;
    localparam logic [1:0]  ADDR_HOLD  = 2'd3;

    localparam int unsigned CB_RUN  = 0;
    localparam int unsigned CB_EXT  = 1;
    localparam int unsigned CB_CAP  = 2;
    localparam int unsigned CB_SRC  = 3;
    localparam int unsigned CB_TX   = 4;
    localparam int unsigned CB_RX   = 5;
    localparam int unsigned CB_EXTF = 6;
    localparam int unsigned CB_OVFF = 7;

    localparam int unsigned OB_DOWN = 0;
    localparam int unsigned OB_TGL  = 1;
    localparam int unsigned OB_IRQ  = 2;

endpackage

// File: rtl/evt_pin_sync.sv
module evt_pin_sync #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] cur_q;
    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cur_q[g]  <= 1'b1;
                prev_q[g] <= 1'b1;
            end else begin
                cur_q[g]  <= pin_i[g];
                prev_q[g] <= cur_q[g];
            end
        end
        assign fall_o[g]  = prev_q[g] & ~cur_q[g];
        assign level_o[g] = cur_q[g];
    end
endmodule

// File: rtl/evt_mode_fsm.sv
module evt_mode_fsm
    import evt_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  tmr_cfg_t   cfg_i,
    output tmr_state_e state_o,
    output logic       run_o,
    output logic       cap_o,
    output logic       rld_o,
    output logic       flag_ok_o,
    output logic       updn_o,
    output logic       wrap_rld_o,
    output logic       ext_irq_ok_o
);
    tmr_state_e state_q, state_d;

    always_comb begin
        if (!cfg_i.run)                      state_d = ST_HALT;
        else if (cfg_i.tx_sel | cfg_i.rx_sel) state_d = ST_BAUD;
        else if (cfg_i.cap_mode)             state_d = ST_CAPTURE;
        else if (cfg_i.down_en)              state_d = ST_UPDN;
        else                                 state_d = ST_RELOAD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        run_o        = 1'b0;
        cap_o        = 1'b0;
        rld_o        = 1'b0;
        flag_ok_o    = 1'b0;
        updn_o       = 1'b0;
        wrap_rld_o   = 1'b0;
        ext_irq_ok_o = 1'b1;
        unique case (state_q)
            ST_HALT: begin
            end
            ST_CAPTURE: begin
                run_o     = 1'b1;
                cap_o     = 1'b1;
                flag_ok_o = 1'b1;
            end
            ST_RELOAD: begin
                run_o      = 1'b1;
                rld_o      = 1'b1;
                flag_ok_o  = 1'b1;
                wrap_rld_o = 1'b1;
            end
            ST_UPDN: begin
                run_o        = 1'b1;
                flag_ok_o    = 1'b1;
                updn_o       = 1'b1;
                wrap_rld_o   = 1'b1;
                ext_irq_ok_o = 1'b0;
            end
            ST_BAUD: begin
                run_o      = 1'b1;
                wrap_rld_o = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign state_o = state_q;

    // R13: any baud select with run set lands in BAUD on the next clock
    assert_baud_first_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.run && (cfg_i.tx_sel || cfg_i.rx_sel)) |=> (state_q == ST_BAUD));
endmodule

// File: rtl/evt_count_core.sv
module evt_count_core #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    input  logic         updn_i,
    input  logic         dir_up_i,
    input  logic         wrap_rld_i,
    input  logic         trig_cap_i,
    input  logic         trig_rld_i,
    input  logic         wr_cnt_i,
    input  logic         wr_hold_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] count_o,
    output logic [W-1:0] hold_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] count_q, hold_q, count_d;
    logic         down, wrap_now;

    assign down     = updn_i & ~dir_up_i;
    assign wrap_now = step_i & (down ? (count_q == hold_q) : (count_q == MAXV));
    assign wrap_o   = wrap_now & ~trig_rld_i & ~wr_cnt_i;

    always_comb begin
        count_d = count_q;
        if (wr_cnt_i)        count_d = wr_data_i;
        else if (trig_rld_i) count_d = hold_q;
        else if (wrap_now) begin
            if (down)            count_d = MAXV;
            else if (wrap_rld_i) count_d = hold_q;
            else                 count_d = '0;
        end else if (step_i) begin
            count_d = down ? count_q - 1'b1 : count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            hold_q  <= '0;
        end else begin
            count_q <= count_d;
            if (wr_hold_i)       hold_q <= wr_data_i;
            else if (trig_cap_i) hold_q <= count_q;
        end
    end

    assign count_o = count_q;
    assign hold_o  = hold_q;

    // R3: an up wrap with reload enabled brings in the holding value
    assert_reload_on_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !updn_i && wrap_rld_i && count_q == MAXV && !trig_rld_i && !wr_cnt_i)
        |=> (count_q == $past(hold_q)));

    // R5: a capture takes the count as it stood before the edge
    assert_capture_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_cap_i && !wr_hold_i) |=> (hold_q == $past(count_q)));

    // R8: down count at the floor goes to all ones
    assert_floor_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && down && count_q == hold_q && !wr_cnt_i && !trig_rld_i)
        |=> (count_q == MAXV));
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
    import evt_timer_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              cnt_in_i,
    input  logic              trig_i,
    input  logic              t1_ovf_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [W-1:0]      wr_data_i,
    output logic              ovf_flag_o,
    output logic              ext_flag_o,
    output logic              irq_o,
    output logic              tx_baud_o,
    output logic              rx_baud_o,
    output logic              tgl_o,
    output logic [W-1:0]      count_o,
    output logic [W-1:0]      hold_o
);
    tmr_cfg_t   cfg_q;
    tmr_state_e state;
    logic run, cap_en, rld_en, flag_ok, updn, wrap_rld, ext_irq_ok;
    logic wr_ctrl, wr_opt, wr_cnt, wr_hold;
    logic [1:0] pin_lvl, pin_fall;
    logic step, trig_evt, wrap, ovf_set, ext_set;
    logic ovf_flag_q, ext_flag_q, ovf_pulse_q, tgl_q;

    assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);
    assign wr_opt  = wr_en_i && (wr_addr_i == ADDR_OPT);
    assign wr_cnt  = wr_en_i && (wr_addr_i == ADDR_COUNT);
    assign wr_hold = wr_en_i && (wr_addr_i == ADDR_HOLD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            if (wr_ctrl) begin
                cfg_q.run      <= wr_data_i[CB_RUN];
                cfg_q.ext_en   <= wr_data_i[CB_EXT];
                cfg_q.cap_mode <= wr_data_i[CB_CAP];
                cfg_q.src_ext  <= wr_data_i[CB_SRC];
                cfg_q.tx_sel   <= wr_data_i[CB_TX];
                cfg_q.rx_sel   <= wr_data_i[CB_RX];
            end
            if (wr_opt) begin
                cfg_q.down_en <= wr_data_i[OB_DOWN];
                cfg_q.out_en  <= wr_data_i[OB_TGL];
                cfg_q.irq_en  <= wr_data_i[OB_IRQ];
            end
        end
    end

    evt_pin_sync #(.N(2)) u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   ({cnt_in_i, trig_i}),
        .level_o (pin_lvl),
        .fall_o  (pin_fall)
    );

    evt_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_i        (cfg_q),
        .state_o      (state),
        .run_o        (run),
        .cap_o        (cap_en),
        .rld_o        (rld_en),
        .flag_ok_o    (flag_ok),
        .updn_o       (updn),
        .wrap_rld_o   (wrap_rld),
        .ext_irq_ok_o (ext_irq_ok)
    );

    assign step     = run & (cfg_q.src_ext ? pin_fall[1] : tick_i);
    assign trig_evt = pin_fall[0] & cfg_q.ext_en;

    evt_count_core #(.W(W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step),
        .updn_i     (updn),
        .dir_up_i   (pin_lvl[0]),
        .wrap_rld_i (wrap_rld),
        .trig_cap_i (trig_evt & cap_en),
        .trig_rld_i (trig_evt & rld_en),
        .wr_cnt_i   (wr_cnt),
        .wr_hold_i  (wr_hold),
        .wr_data_i  (wr_data_i),
        .count_o    (count_o),
        .hold_o     (hold_o),
        .wrap_o     (wrap)
    );

    assign ovf_set = wrap & ~(cfg_q.tx_sel | cfg_q.rx_sel);
    assign ext_set = trig_evt & flag_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_flag_q  <= 1'b0;
            ext_flag_q  <= 1'b0;
            ovf_pulse_q <= 1'b0;
            tgl_q       <= 1'b0;
        end else begin
            ovf_flag_q  <= ovf_set | (wr_ctrl ? wr_data_i[CB_OVFF] : ovf_flag_q);
            ext_flag_q  <= ext_set | (wr_ctrl ? wr_data_i[CB_EXTF] : ext_flag_q);
            ovf_pulse_q <= wrap;
            if (wrap && cfg_q.out_en) tgl_q <= ~tgl_q;
        end
    end

    assign ovf_flag_o = ovf_flag_q;
    assign ext_flag_o = ext_flag_q;
    assign irq_o      = cfg_q.irq_en & (ovf_flag_q | (ext_flag_q & ext_irq_ok));
    assign tx_baud_o  = cfg_q.tx_sel ? ovf_pulse_q : t1_ovf_i;
    assign rx_baud_o  = cfg_q.rx_sel ? ovf_pulse_q : t1_ovf_i;
    assign tgl_o      = tgl_q;

    // R2: halted timer keeps its count unless software loads it
    assert_halt_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !wr_cnt) |=> $stable(count_o));

    // R4: overflow flag is sticky until software clears it
    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag_q && !wr_ctrl) |=> ovf_flag_q);

    // R4: no hardware overflow flag while a baud select is set
    assert_no_ovf_in_baud_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_q.tx_sel || cfg_q.rx_sel) && !wr_ctrl && !ovf_flag_q) |=> !ovf_flag_q);

    // R6: disabled trigger never raises the external flag
    assert_ext_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.ext_en && !wr_ctrl && !ext_flag_q) |=> !ext_flag_q);

    // R9: external flag is silent in up/down mode
    assert_updn_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UPDN && !ovf_flag_q) |-> !irq_o);

    // R12: hardware set wins over a same-cycle software clear
    assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !cfg_q.tx_sel && !cfg_q.rx_sel && wr_ctrl && !wr_data_i[CB_OVFF]) |=> ovf_flag_q);

    // R11: an overflow with the pin enabled flips the pin
    assert_toggle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && cfg_q.out_en) |=> (tgl_q != $past(tgl_q)));
endmodule

// File: tb/evt_timer16_bench.sv
`timescale 1ns/1ps
module evt_timer16_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0, cnt_in_i = 1'b1, trig_i = 1'b1, t1_ovf_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_addr_i = '0;
    logic [15:0] wr_data_i = '0;
    logic        ovf_flag_o, ext_flag_o, irq_o, tx_baud_o, rx_baud_o, tgl_o;
    logic [15:0] count_o, hold_o;
    int          n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    evt_timer16 u_evt_timer16 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cnt_in_i(cnt_in_i),
        .trig_i(trig_i), .t1_ovf_i(t1_ovf_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .ovf_flag_o(ovf_flag_o), .ext_flag_o(ext_flag_o), .irq_o(irq_o),
        .tx_baud_o(tx_baud_o), .rx_baud_o(rx_baud_o), .tgl_o(tgl_o),
        .count_o(count_o), .hold_o(hold_o)
    );

    // hold, start count, ticks, expected count, expected overflow flag (RELOAD mode, R3)
    localparam logic [56:0] VEC [5] = '{
        {16'h1234, 16'hFFFE, 8'd1,  16'hFFFF, 1'b0},
        {16'h1234, 16'hFFFE, 8'd2,  16'h1234, 1'b1},
        {16'h1234, 16'hFFFF, 8'd1,  16'h1234, 1'b1},
        {16'h1234, 16'h0010, 8'd5,  16'h0015, 1'b0},
        {16'hFFF0, 16'hFFFF, 8'd17, 16'hFFF0, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            tick_i = 1'b1;
            repeat (n) @(negedge clk);
            tick_i = 1'b0;
        end
    endtask

    task automatic trig_edge();
        trig_i = 1'b0; idle(2);
        trig_i = 1'b1; idle(2);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk("R1 count", count_o, 0);
        chk("R1 hold", hold_o, 0);
        chk("R1 ovf", ovf_flag_o, 0);
        chk("R1 ext", ext_flag_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 tgl", tgl_o, 0);
        chk("R1 tx", tx_baud_o, 0);

        // R2 halted
        wr(2, 16'h0042); ticks(4);
        chk("R2 halt hold", count_o, 16'h0042);

        // R3 vector walk
        wr(0, 16'h0001); idle(1);
        for (int i = 0; i < 5; i++) begin
            wr(3, VEC[i][56:41]);
            wr(2, VEC[i][40:25]);
            wr(0, 16'h0001);
            ticks(int'(VEC[i][24:17]));
            chk("R3 vec count", count_o, VEC[i][16:1]);
            chk("R3 vec ovf", ovf_flag_o, VEC[i][0]);
        end

        // R4 sticky then software clear
        wr(2, 16'hFFFF); ticks(1); idle(5);
        chk("R4 sticky", ovf_flag_o, 1);
        wr(0, 16'h0001);
        chk("R4 sw clear", ovf_flag_o, 0);

        // R12 clear coinciding with overflow
        wr(3, 16'h0000); wr(2, 16'hFFFF);
        wr_en_i = 1'b1; wr_addr_i = 2'd0; wr_data_i = 16'h0001; tick_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; tick_i = 1'b0;
        chk("R12 set wins", ovf_flag_o, 1);
        chk("R12 count", count_o, 16'h0000);

        // R2 external count source
        wr(2, 16'h0000); wr(0, 16'h0009); idle(1);
        ticks(3);
        for (int i = 0; i < 3; i++) begin
            cnt_in_i = 1'b0; idle(2); cnt_in_i = 1'b1; idle(1);
        end
        chk("R2 ext source", count_o, 16'h0003);

        // R11 toggle pin
        wr(0, 16'h0001); wr(1, 16'h0002); idle(1);
        wr(2, 16'hFFFF); ticks(1);
        chk("R11 toggle on", tgl_o, 1);
        wr(2, 16'hFFFF); ticks(1);
        chk("R11 toggle off", tgl_o, 0);

        // R5 capture
        wr(1, 16'h0004); wr(0, 16'h0007); idle(1);
        wr(2, 16'h0100); wr(3, 16'h0000);
        trig_edge();
        chk("R5 capture hold", hold_o, 16'h0100);
        chk("R5 ext flag", ext_flag_o, 1);
        chk("R9 irq ext", irq_o, 1);
        ticks(1);
        chk("R5 keeps counting", count_o, 16'h0101);

        // R6 trigger disabled
        wr(0, 16'h0005); idle(1);
        wr(2, 16'h0200);
        trig_edge();
        chk("R6 hold unchanged", hold_o, 16'h0100);
        chk("R6 no ext flag", ext_flag_o, 0);

        // R7 reload on trigger
        wr(0, 16'h0003); idle(1);
        wr(3, 16'hABCD); wr(2, 16'h0005);
        trig_edge();
        chk("R7 reload", count_o, 16'hABCD);
        chk("R7 ext flag", ext_flag_o, 1);

        // R8 up/down
        wr(1, 16'h0005); wr(0, 16'h0001); idle(1);
        trig_i = 1'b0; idle(1);
        wr(3, 16'h0100); wr(2, 16'h0102);
        ticks(3);
        chk("R8 down floor wrap", count_o, 16'hFFFF);
        chk("R8 ovf", ovf_flag_o, 1);
        trig_i = 1'b1; idle(2);
        ticks(1);
        chk("R8 up wrap", count_o, 16'h0100);
        wr(0, 16'h0003); idle(1);
        trig_edge();
        chk("R9 ext flag set", ext_flag_o, 1);
        chk("R9 no irq", irq_o, 0);
        chk("R8 no reload", count_o, 16'h0100);

        // R10 baud
        wr(1, 16'h0004); wr(0, 16'h0013); idle(1);
        wr(3, 16'hFFFE); wr(2, 16'hFFFF);
        t1_ovf_i = 1'b1;
        chk("R10 rx mirrors", rx_baud_o, 1);
        chk("R10 tx idle", tx_baud_o, 0);
        t1_ovf_i = 1'b0;
        ticks(1);
        chk("R10 tx pulse", tx_baud_o, 1);
        chk("R4 no ovf in baud", ovf_flag_o, 0);
        chk("R10 baud reload", count_o, 16'hFFFE);
        idle(1);
        chk("R10 pulse ends", tx_baud_o, 0);
        trig_edge();
        chk("R6 baud ignores trig", ext_flag_o, 0);

        // R13 baud over capture
        wr(0, 16'h0017); idle(1);
        trig_edge();
        chk("R13 no capture", hold_o, 16'hFFFE);
        chk("R13 no ext", ext_flag_o, 0);

        finish_run();
    end
endmodule